// File: doc/BRIEF.md
# Delay-Lock Body-Bias Controller

This block holds the evaluation delay of a reference logic array at a fixed point inside each period of an external beat clock. The array lowers an active-low completion line once every one of its outputs has resolved. On each rising beat edge the controller looks at that line. A line that is still high means the array is late, and the controller raises a saturating bias code one step toward stronger forward body bias. A line that is already low means the array is early, and the code falls one step toward zero bias. The code never goes below zero, so reverse bias is never requested.

The bias code and a pair of one-cycle up/down strobes drive a downstream charge pump, which is outside this block. A lock flag reports when the loop is dithering around its balance point, and drops when the loop is plainly slewing. Both asynchronous inputs are synchronised into the controller clock through the same depth of flops, so they stay aligned with each other.

Top module: `dlb_lock_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `bias_code` is 0, both strobes are 0 and `locked` is 0.
- R2: Each rising edge of `beat_clk` produces exactly one decision, sampled with `done_n` at that edge: high means late, low means early. With the default two synchroniser stages, the decision reaches the outputs at the fourth rising `clk` edge after both inputs settle.
- R3: A late decision adds 1 to `bias_code`. At the maximum code (63 for the default 6-bit width) the code stays put.
- R4: An early decision subtracts 1 from `bias_code`. At 0 the code stays put.
- R5: `step_up` or `step_dn` is high for exactly the one cycle in which `bias_code` has just risen or fallen. Neither is high when a decision is absorbed by saturation. The two are never high together.
- R6: `locked` sets when the 4 most recent decisions alternate in direction (for example late, early, late, early).
- R7: `locked` clears when the 3 most recent decisions share one direction, and is otherwise left unchanged.
- R8: When the array delay falls by one step per code unit, the code settles within one step of the balance point where the delay equals the time from period start to the beat edge, and `locked` is high there. After the array's base delay steps up or down, the code settles again and lock returns.
- R9: Between decisions, `bias_code` holds its value, whatever `done_n` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| beat_clk | input | 1 | External beat clock; its rising edge is the timing reference |
| done_n | input | 1 | Active-low completion from the reference array |
| bias_code | output | 6 | Saturating forward-bias code, 0 = zero bias |
| step_up | output | 1 | One-cycle pulse when the code has just increased |
| step_dn | output | 1 | One-cycle pulse when the code has just decreased |
| locked | output | 1 | High while decisions alternate around the balance point |

## Verification
The bench closes the loop with a behavioural array model. In that model, completion falls a number of cycles after period start equal to a base delay minus the bias code. The bench drives the loop from zero up to its balance point, then steps the base delay up and down, then forces it far out on both sides. A design that mishandled saturation would wrap from 63 to 0 or from 0 to 63 and show a large step in the code. It would also pulse a strobe that the pump must not see. A completion edge that lands on the same cycle as the beat edge must count as early; a detector that flipped that tie would settle one code away from the expected point. A lock monitor that counted runs wrongly would either never lock while dithering, or stay locked while the code slews for tens of beats after a delay step.

// File: rtl/dlb_pkg.sv
package dlb_pkg;

    localparam int unsigned DLB_CODE_W    = 6;
    localparam int unsigned DLB_SYNC_N    = 2;
    localparam int unsigned DLB_ALT_RUN   = 4;
    localparam int unsigned DLB_SAME_RUN  = 3;

    // One phase decision per beat edge
    typedef struct packed {
        logic valid;
        logic late;
    } verdict_t;

    typedef enum logic [1:0] {
        MOVE_HOLD = 2'd0,
        MOVE_UP   = 2'd1,
        MOVE_DN   = 2'd2
    } move_e;

    // Turns a decision into a code move, absorbing it at either rail
    function automatic move_e pick_move(verdict_t v, logic at_top, logic at_floor);
        if (!v.valid) begin
            return MOVE_HOLD;
        end else if (v.late) begin
            return at_top ? MOVE_HOLD : MOVE_UP;
        end else begin
            return at_floor ? MOVE_HOLD : MOVE_DN;
        end
    endfunction

endpackage

// File: rtl/dlb_sync.sv
module dlb_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= d_in;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign d_out = chain[STAGES-1];

endmodule

// File: rtl/dlb_phase_det.sv
module dlb_phase_det
    import dlb_pkg::*;
#(
    parameter int unsigned SYNC_N = DLB_SYNC_N
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     beat_clk,
    input  logic     done_n,
    output verdict_t verdict
);

    localparam int unsigned LINES = 2;

    logic [LINES-1:0] raw_lines;
    logic [LINES-1:0] sync_lines;
    logic             beat_s;
    logic             done_s;
    logic             beat_prev;
    logic             beat_rise;

    assign raw_lines = {beat_clk, done_n};

    dlb_sync #(
        .WIDTH  (LINES),
        .STAGES (SYNC_N)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (raw_lines),
        .d_out (sync_lines)
    );

    assign beat_s    = sync_lines[1];
    assign done_s    = sync_lines[0];
    assign beat_rise = beat_s & ~beat_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_prev <= 1'b0;
            verdict   <= '0;
        end else begin
            beat_prev     <= beat_s;
            verdict.valid <= beat_rise;
            // completion still high at the edge: array is late
            verdict.late  <= beat_rise & done_s;
        end
    end

endmodule

// File: rtl/dlb_bias_acc.sv
module dlb_bias_acc
    import dlb_pkg::*;
#(
    parameter int unsigned CODE_W = DLB_CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  verdict_t          verdict,
    output logic [CODE_W-1:0] code,
    output logic              step_up,
    output logic              step_dn
);

    localparam logic [CODE_W-1:0] CODE_TOP   = '1;
    localparam logic [CODE_W-1:0] CODE_FLOOR = '0;

    move_e move;

    always_comb begin
        move = pick_move(verdict, code == CODE_TOP, code == CODE_FLOOR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code    <= CODE_FLOOR;
            step_up <= 1'b0;
            step_dn <= 1'b0;
        end else begin
            step_up <= (move == MOVE_UP);
            step_dn <= (move == MOVE_DN);
            case (move)
                MOVE_UP: code <= code + 1'b1;
                MOVE_DN: code <= code - 1'b1;
                default: code <= code;
            endcase
        end
    end

endmodule

// File: rtl/dlb_lock_mon.sv
module dlb_lock_mon
    import dlb_pkg::*;
#(
    parameter int unsigned ALT_RUN  = DLB_ALT_RUN,
    parameter int unsigned SAME_RUN = DLB_SAME_RUN
) (
    input  logic     clk,
    input  logic     rst,
    input  verdict_t verdict,
    output logic     locked
);

    localparam int unsigned RUN_MAX = (ALT_RUN > SAME_RUN) ? ALT_RUN : SAME_RUN;
    localparam int unsigned RUN_W   = $clog2(RUN_MAX + 1);
    localparam logic [RUN_W-1:0] ALT_LIM  = RUN_W'(ALT_RUN);
    localparam logic [RUN_W-1:0] SAME_LIM = RUN_W'(SAME_RUN);
    localparam logic [RUN_W-1:0] RUN_ONE  = RUN_W'(1);

    logic             seen_q;
    logic             prev_late_q;
    logic [RUN_W-1:0] alt_q,  alt_d;
    logic [RUN_W-1:0] same_q, same_d;
    logic             lock_d;

    always_comb begin
        alt_d  = alt_q;
        same_d = same_q;
        lock_d = locked;
        if (verdict.valid) begin
            if (!seen_q) begin
                alt_d  = RUN_ONE;
                same_d = RUN_ONE;
            end else if (verdict.late != prev_late_q) begin
                alt_d  = (alt_q == ALT_LIM) ? alt_q : alt_q + RUN_ONE;
                same_d = RUN_ONE;
            end else begin
                alt_d  = RUN_ONE;
                same_d = (same_q == SAME_LIM) ? same_q : same_q + RUN_ONE;
            end
            if (alt_d == ALT_LIM) begin
                lock_d = 1'b1;
            end else if (same_d == SAME_LIM) begin
                lock_d = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q      <= 1'b0;
            prev_late_q <= 1'b0;
            alt_q       <= '0;
            same_q      <= '0;
            locked      <= 1'b0;
        end else begin
            alt_q  <= alt_d;
            same_q <= same_d;
            locked <= lock_d;
            if (verdict.valid) begin
                seen_q      <= 1'b1;
                prev_late_q <= verdict.late;
            end
        end
    end

endmodule

// File: rtl/dlb_lock_ctrl.sv
module dlb_lock_ctrl
    import dlb_pkg::*;
#(
    parameter int unsigned CODE_W   = DLB_CODE_W,
    parameter int unsigned SYNC_N   = DLB_SYNC_N,
    parameter int unsigned ALT_RUN  = DLB_ALT_RUN,
    parameter int unsigned SAME_RUN = DLB_SAME_RUN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              beat_clk,
    input  logic              done_n,
    output logic [CODE_W-1:0] bias_code,
    output logic              step_up,
    output logic              step_dn,
    output logic              locked
);

    verdict_t verdict;

    dlb_phase_det #(
        .SYNC_N (SYNC_N)
    ) u_det (
        .clk      (clk),
        .rst      (rst),
        .beat_clk (beat_clk),
        .done_n   (done_n),
        .verdict  (verdict)
    );

    dlb_bias_acc #(
        .CODE_W (CODE_W)
    ) u_acc (
        .clk     (clk),
        .rst     (rst),
        .verdict (verdict),
        .code    (bias_code),
        .step_up (step_up),
        .step_dn (step_dn)
    );

    dlb_lock_mon #(
        .ALT_RUN  (ALT_RUN),
        .SAME_RUN (SAME_RUN)
    ) u_lock (
        .clk     (clk),
        .rst     (rst),
        .verdict (verdict),
        .locked  (locked)
    );

endmodule

// File: rtl/dlb_lock_chk.sv
module dlb_lock_chk
    import dlb_pkg::*;
#(
    parameter int unsigned CODE_W = DLB_CODE_W
) (
    input logic              clk,
    input logic              rst,
    input logic [CODE_W-1:0] bias_code,
    input logic              step_up,
    input logic              step_dn,
    input logic              locked,
    input verdict_t          verdict
);

    localparam logic [CODE_W-1:0] TOP = '1;

    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    assert_one_dir_R5: assert property (@(posedge clk) disable iff (rst)
        !(step_up && step_dn));

    assert_up_step_R3: assert property (@(posedge clk) disable iff (rst)
        (past_ok && step_up) |-> (bias_code == CODE_W'($past(bias_code) + 1'b1) && $past(bias_code) != TOP));

    assert_dn_step_R4: assert property (@(posedge clk) disable iff (rst)
        (past_ok && step_dn) |-> (bias_code == CODE_W'($past(bias_code) - 1'b1) && $past(bias_code) != '0));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !step_up && !step_dn) |-> $stable(bias_code));

    assert_move_from_verdict_R2: assert property (@(posedge clk) disable iff (rst)
        (past_ok && step_up) |-> ($past(verdict.valid) && $past(verdict.late)));

    assert_down_from_verdict_R2: assert property (@(posedge clk) disable iff (rst)
        (past_ok && step_dn) |-> ($past(verdict.valid) && !$past(verdict.late)));

    assert_lock_rise_R6: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $rose(locked)) |-> $past(verdict.valid));

    assert_lock_fall_R7: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $fell(locked)) |-> $past(verdict.valid));

endmodule

bind dlb_lock_ctrl dlb_lock_chk #(
    .CODE_W (CODE_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bias_code (bias_code),
    .step_up   (step_up),
    .step_dn   (step_dn),
    .locked    (locked),
    .verdict   (verdict)
);

// File: tb/test_dlb_lock_ctrl.sv
`timescale 1ns/1ps
module test_dlb_lock_ctrl;

    localparam int PERIOD = 40;   // clk cycles per beat period
    localparam int EDGE_AT = 20;  // beat rises this many cycles into the period
    localparam int K = 1;         // delay cycles removed per code unit
    localparam int TOPC = 63;
    localparam int LAT = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       beat_clk = 1'b0;
    logic       done_n = 1'b1;
    logic [5:0] bias_code;
    logic       step_up, step_dn, locked;

    int errors = 0;
    int checks = 0;
    bit cmp_on = 1'b0;
    bit finished = 1'b0;

    // reference model state
    int exp_code = 0;
    bit exp_up = 0, exp_dn = 0, exp_lock = 0;
    bit have_prev = 0, prev_late = 0;
    int alt_run = 0, same_run = 0;
    int pend_cnt = 0;
    bit pend_late = 0;
    int base = 45;

    always #2 clk = ~clk;

    dlb_lock_ctrl i_dlb_lock_ctrl (
        .clk       (clk),
        .rst       (rst),
        .beat_clk  (beat_clk),
        .done_n    (done_n),
        .bias_code (bias_code),
        .step_up   (step_up),
        .step_dn   (step_dn),
        .locked    (locked)
    );

    task automatic apply_decision(input bit late);
        if (late) begin
            if (exp_code < TOPC) begin exp_code++; exp_up = 1; end
        end else begin
            if (exp_code > 0) begin exp_code--; exp_dn = 1; end
        end
        if (!have_prev) begin
            alt_run = 1; same_run = 1;
        end else if (late != prev_late) begin
            alt_run = (alt_run >= 4) ? 4 : alt_run + 1; same_run = 1;
        end else begin
            alt_run = 1; same_run = (same_run >= 3) ? 3 : same_run + 1;
        end
        have_prev = 1; prev_late = late;
        if (alt_run >= 4) exp_lock = 1;
        else if (same_run >= 3) exp_lock = 0;
    endtask

    always @(posedge clk) begin
        exp_up = 0; exp_dn = 0;
        if (rst) begin
            exp_code = 0; exp_lock = 0; have_prev = 0; prev_late = 0;
            alt_run = 0; same_run = 0; pend_cnt = 0;
        end else if (pend_cnt > 0) begin
            pend_cnt--;
            if (pend_cnt == 0) apply_decision(pend_late);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (cmp_on && !rst && !finished) begin
            check(int'(bias_code) == exp_code, "R2 R3 R4 R9 bias_code", int'(bias_code), exp_code);
            check(step_up == exp_up, "R5 step_up", int'(step_up), int'(exp_up));
            check(step_dn == exp_dn, "R5 step_dn", int'(step_dn), int'(exp_dn));
            check(locked == exp_lock, "R6 R7 locked", int'(locked), int'(exp_lock));
        end
    end

    task automatic run_beats(input int n);
        for (int b = 0; b < n; b++) begin
            int d;
            @(negedge clk);
            beat_clk = 1'b0;
            done_n = 1'b1;
            d = base - K * exp_code;
            if (d < 1) d = 1;
            for (int i = 1; i < PERIOD; i++) begin
                @(negedge clk);
                if (i == d) done_n = 1'b0;
                if (i == EDGE_AT) begin
                    beat_clk = 1'b1;
                    pend_late = (d > EDGE_AT);   // tie counts as early
                    pend_cnt = LAT;
                end
            end
        end
    endtask

    task automatic check_settled(input string tag);
        int lo, hi;
        lo = base - EDGE_AT - 1;
        hi = base - EDGE_AT;
        check(int'(bias_code) >= lo && int'(bias_code) <= hi, {"R8 settle code ", tag}, int'(bias_code), hi);
        check(locked == 1'b1, {"R8 settle lock ", tag}, int'(locked), 1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        cmp_on = 1'b0;
        rst = 1'b1;
        beat_clk = 1'b0;
        done_n = 1'b1;
        repeat (3) @(negedge clk);
        check(bias_code == 6'd0 && !step_up && !step_dn && !locked, "R1 during reset",
              int'(bias_code) + int'(step_up) + int'(step_dn) + int'(locked), 0);
        rst = 1'b0;
        @(negedge clk);
        check(bias_code == 6'd0, "R1 code after reset", int'(bias_code), 0);
        check(!step_up && !step_dn, "R1 strobes after reset", int'(step_up) + int'(step_dn), 0);
        check(!locked, "R1 lock after reset", int'(locked), 0);
        cmp_on = 1'b1;
    endtask

    initial begin
        do_reset();
        // converge from zero bias
        base = 45;
        run_beats(45);
        check_settled("base45");
        // array slows down: more forward bias needed
        base = 55;
        run_beats(30);
        check_settled("base55");
        // array speeds up: bias falls back
        base = 30;
        run_beats(45);
        check_settled("base30");
        // far too slow: code pins at its top
        base = 110;
        run_beats(70);
        check(int'(bias_code) == TOPC, "R3 saturate top", int'(bias_code), TOPC);
        check(!locked, "R7 unlocked at top", int'(locked), 0);
        // mid-run reset
        do_reset();
        // far too fast: code pins at zero, no down strobes
        base = 8;
        run_beats(12);
        check(bias_code == 6'd0, "R4 saturate floor", int'(bias_code), 0);
        check(!locked, "R7 unlocked at floor", int'(locked), 0);
        // re-lock from the floor
        base = 26;
        run_beats(20);
        check_settled("base26");
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule